// File: doc/BRIEF.md
# Wishbone Address Decoder with Translation

This block connects one Wishbone initiator to four subordinates placed at fixed windows of the initiator's address space. It is purely combinational. It compares the initiator word address against each window and raises `cyc` only on the subordinate that owns the address. It then returns that subordinate's read data and response flags to the initiator. The decoder adds no cycles to a transfer.

The initiator side has a 20-bit word address, 32-bit data and 16-bit granularity, so it carries two select bits. A subordinate may be dense, with the full data width and a finer granularity. Such a subordinate receives a widened select vector. A subordinate may instead be sparse: its data width equals its granularity, so it sees only the low lane. Subordinate 1 also carries the optional lock, cycle-type, burst-type, error, retry and stall signals. The other subordinates lack them, and the initiator sees those flags as 0 whenever one of the others is addressed.

Flow control: `m_stb` qualified by `m_cyc` acts as the valid of a request, and `m_stall` acts as its back-pressure. A request is accepted on a cycle with `m_stb` high and `m_stall` low. `m_ack`, `m_err` and `m_rty` end a transfer. All of these come straight from the addressed subordinate in the same cycle, with no buffering. When no window matches, stall and every response read 0, so the initiator must not wait for an answer from an unmapped address.

Top module: `wb_addr_decoder`

## Requirements
- R1: For each subordinate, `sK_cyc` is 1 only when `m_cyc` is 1 and the word address lies inside that subordinate's window. At most one `sK_cyc` is 1 at any time.
- R2: `m_stb` and `m_we` reach every subordinate unqualified. Each subordinate's translated select and write data are driven whether or not its window is addressed.
- R3: `m_ack`, `m_err`, `m_rty`, `m_stall` and `m_dat_r` are taken only from the subordinate whose window holds the address. Flags raised by any other subordinate have no effect.
- R4: `m_lock` (1 bit), `m_cti` (3 bits) and `m_bte` (2 bits) appear unchanged on `s1_lock`, `s1_cti` and `s1_bte`.
- R5: While subordinate 0, 2 or 3 is addressed, `m_err`, `m_rty` and `m_stall` are 0, because these subordinates have no such outputs.
- R6: Subordinate 1 is dense with 8-bit granularity. Initiator select bit i drives `s1_sel` bits 2i and 2i+1, write and read data pass at full width, and `m_dat_r` equals `s1_dat_r`. Subordinate 0 is dense with 16-bit granularity, and `s0_sel` equals `m_sel`.
- R7: Subordinates 2 (16-bit) and 3 (8-bit) are sparse. Their 1-bit select equals `m_sel[0]`, and their write data is the low lane of `m_dat_w`. `m_dat_r` returns their data in the low bits, with the upper bits 0.
- R8: Each subordinate's address is the initiator word address minus the window's base word, truncated to that subordinate's address width: 7 bits for subordinates 0, 2 and 3, and 6 bits for subordinate 1.
- R9: When no window matches, every `sK_cyc` is 0, and `m_ack`, `m_err`, `m_rty`, `m_stall` and `m_dat_r` are 0, whatever the subordinates drive.
- R10: The windows, as word ranges, are: subordinate 0 at 0x08000–0x0807F, subordinate 1 at 0x10000–0x1003F, subordinate 2 at 0x18000–0x1807F and subordinate 3 at 0x20000–0x2007F. In 16-bit units these are bases 0x10000, 0x20000, 0x30000 and 0x40000, with spans 0x100, 0x80, 0x100 and 0x100. The first and last word of each window match, and the word just outside a window does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| m_cyc | input | 1 | Initiator bus cycle active |
| m_stb | input | 1 | Initiator request valid |
| m_we | input | 1 | Initiator write enable |
| m_adr | input | 20 | Initiator word address |
| m_sel | input | 2 | Initiator 16-bit lane selects |
| m_dat_w | input | 32 | Initiator write data |
| m_lock | input | 1 | Initiator bus lock |
| m_cti | input | 3 | Initiator cycle type |
| m_bte | input | 2 | Initiator burst type |
| m_dat_r | output | 32 | Read data to initiator |
| m_ack | output | 1 | Transfer acknowledge to initiator |
| m_err | output | 1 | Error response to initiator |
| m_rty | output | 1 | Retry response to initiator |
| m_stall | output | 1 | Back-pressure to initiator |
| s0_cyc | output | 1 | Subordinate 0 cycle |
| s0_stb | output | 1 | Subordinate 0 request |
| s0_we | output | 1 | Subordinate 0 write enable |
| s0_adr | output | 7 | Subordinate 0 word address |
| s0_sel | output | 2 | Subordinate 0 selects (16-bit lanes) |
| s0_dat_w | output | 32 | Subordinate 0 write data |
| s0_dat_r | input | 32 | Subordinate 0 read data |
| s0_ack | input | 1 | Subordinate 0 acknowledge |
| s1_cyc | output | 1 | Subordinate 1 cycle |
| s1_stb | output | 1 | Subordinate 1 request |
| s1_we | output | 1 | Subordinate 1 write enable |
| s1_adr | output | 6 | Subordinate 1 word address |
| s1_sel | output | 4 | Subordinate 1 selects (8-bit lanes) |
| s1_dat_w | output | 32 | Subordinate 1 write data |
| s1_lock | output | 1 | Subordinate 1 bus lock |
| s1_cti | output | 3 | Subordinate 1 cycle type |
| s1_bte | output | 2 | Subordinate 1 burst type |
| s1_dat_r | input | 32 | Subordinate 1 read data |
| s1_ack | input | 1 | Subordinate 1 acknowledge |
| s1_err | input | 1 | Subordinate 1 error |
| s1_rty | input | 1 | Subordinate 1 retry |
| s1_stall | input | 1 | Subordinate 1 stall |
| s2_cyc | output | 1 | Subordinate 2 cycle |
| s2_stb | output | 1 | Subordinate 2 request |
| s2_we | output | 1 | Subordinate 2 write enable |
| s2_adr | output | 7 | Subordinate 2 word address |
| s2_sel | output | 1 | Subordinate 2 select |
| s2_dat_w | output | 16 | Subordinate 2 write data |
| s2_dat_r | input | 16 | Subordinate 2 read data |
| s2_ack | input | 1 | Subordinate 2 acknowledge |
| s3_cyc | output | 1 | Subordinate 3 cycle |
| s3_stb | output | 1 | Subordinate 3 request |
| s3_we | output | 1 | Subordinate 3 write enable |
| s3_adr | output | 7 | Subordinate 3 word address |
| s3_sel | output | 1 | Subordinate 3 select |
| s3_dat_w | output | 8 | Subordinate 3 write data |
| s3_dat_r | input | 8 | Subordinate 3 read data |
| s3_ack | input | 1 | Subordinate 3 acknowledge |

## Verification
Every result of this block is due in the same cycle as its stimulus. This covers the gated cycle, the translated address, select and data, and the returned data and flags, because no register lies on any path. The bench changes inputs on the falling clock edge and samples 5 ns later, once the combinational paths have settled and well before the next rising edge. The bench's loopback subordinates return their own address plus the lane index on every selected lane. This lets each read value be predicted from the requirements alone, for every select pattern in every window.

// File: rtl/wbdec_pkg.sv
package wbdec_pkg;
  // Address translation variant for one subordinate window
  typedef enum logic {
    XL_DENSE  = 1'b0,
    XL_SPARSE = 1'b1
  } xlate_e;

  localparam int DEC_PORTS = 4;
endpackage

// File: rtl/wbdec_window.sv
module wbdec_window #(
  parameter int M_AW   = 20,
  parameter int BASE_W = 0,
  parameter int SPAN_W = 1
) (
  input  logic [M_AW-1:0] m_adr,
  output logic            hit,
  output logic [M_AW-1:0] offs
);
  localparam logic [M_AW:0] BASE_V = (M_AW+1)'(BASE_W);
  localparam logic [M_AW:0] SPAN_V = (M_AW+1)'(SPAN_W);
  localparam logic [M_AW:0] LIM_V  = BASE_V + SPAN_V;

  logic [M_AW:0] adr_x;
  assign adr_x = {1'b0, m_adr};
  assign hit   = (adr_x >= BASE_V) && (adr_x < LIM_V);
  assign offs  = m_adr - BASE_V[M_AW-1:0];

  always_comb begin
    if (hit) begin
      // R8
      offs_in_span_chk: assert ({1'b0, offs} < SPAN_V);
    end
  end
endmodule

// File: rtl/wbdec_lanes.sv
module wbdec_lanes
  import wbdec_pkg::*;
#(
  parameter xlate_e MODE   = XL_DENSE,
  parameter int     M_DW   = 32,
  parameter int     M_GRAN = 16,
  parameter int     S_DW   = 32,
  parameter int     S_GRAN = 16,
  localparam int    M_SW   = M_DW / M_GRAN,
  localparam int    S_SW   = S_DW / S_GRAN,
  localparam int    RATIO  = M_GRAN / S_GRAN
) (
  input  logic [M_SW-1:0] m_sel,
  input  logic [M_DW-1:0] m_dat_w,
  output logic [S_SW-1:0] s_sel,
  output logic [S_DW-1:0] s_dat_w,
  input  logic [S_DW-1:0] s_dat_r,
  output logic [M_DW-1:0] r_dat
);
  generate
    if (MODE == XL_DENSE) begin : g_dense
      for (genvar i = 0; i < M_SW; i++) begin : g_grp
        for (genvar j = 0; j < RATIO; j++) begin : g_bit
          assign s_sel[i*RATIO + j] = m_sel[i];
        end
      end
      assign s_dat_w = m_dat_w;
      assign r_dat   = s_dat_r;

      always_comb begin
        // R6
        sel_expand_chk: assert ($countones(s_sel) == RATIO * $countones(m_sel));
      end
    end else begin : g_sparse
      logic sparse_unused;
      assign sparse_unused = ^{m_sel[M_SW-1:1], m_dat_w[M_DW-1:S_DW]};
      assign s_sel   = m_sel[0];
      assign s_dat_w = m_dat_w[S_DW-1:0];
      assign r_dat   = {{(M_DW-S_DW){1'b0}}, s_dat_r};
    end
  endgenerate
endmodule

// File: rtl/wbdec_slice.sv
module wbdec_slice
  import wbdec_pkg::*;
#(
  parameter xlate_e MODE      = XL_DENSE,
  parameter int     M_AW      = 20,
  parameter int     M_DW      = 32,
  parameter int     M_GRAN    = 16,
  parameter int     S_AW      = 7,
  parameter int     S_DW      = 32,
  parameter int     S_GRAN    = 16,
  parameter int     BASE_W    = 0,
  parameter int     SPAN_W    = 1,
  parameter bit     HAS_ERR   = 1'b0,
  parameter bit     HAS_RTY   = 1'b0,
  parameter bit     HAS_STALL = 1'b0,
  localparam int    M_SW      = M_DW / M_GRAN,
  localparam int    S_SW      = S_DW / S_GRAN
) (
  input  logic [M_AW-1:0] m_adr,
  input  logic            m_cyc,
  input  logic [M_SW-1:0] m_sel,
  input  logic [M_DW-1:0] m_dat_w,
  output logic            hit,
  output logic            s_cyc,
  output logic [S_AW-1:0] s_adr,
  output logic [S_SW-1:0] s_sel,
  output logic [S_DW-1:0] s_dat_w,
  input  logic [S_DW-1:0] s_dat_r,
  input  logic            s_ack,
  input  logic            s_err,
  input  logic            s_rty,
  input  logic            s_stall,
  output logic [M_DW-1:0] r_dat,
  output logic            r_ack,
  output logic            r_err,
  output logic            r_rty,
  output logic            r_stall
);
  logic [M_AW-1:0]      offs;
  logic [M_AW-S_AW-1:0] offs_hi_unused;

  wbdec_window #(
    .M_AW  (M_AW),
    .BASE_W(BASE_W),
    .SPAN_W(SPAN_W)
  ) u_window (
    .m_adr(m_adr),
    .hit  (hit),
    .offs (offs)
  );

  assign s_adr          = offs[S_AW-1:0];
  assign offs_hi_unused = offs[M_AW-1:S_AW];
  assign s_cyc          = m_cyc & hit;

  wbdec_lanes #(
    .MODE  (MODE),
    .M_DW  (M_DW),
    .M_GRAN(M_GRAN),
    .S_DW  (S_DW),
    .S_GRAN(S_GRAN)
  ) u_lanes (
    .m_sel  (m_sel),
    .m_dat_w(m_dat_w),
    .s_sel  (s_sel),
    .s_dat_w(s_dat_w),
    .s_dat_r(s_dat_r),
    .r_dat  (r_dat)
  );

  // Responses a subordinate does not implement are forced low
  assign r_ack   = s_ack;
  assign r_err   = HAS_ERR   ? s_err   : 1'b0;
  assign r_rty   = HAS_RTY   ? s_rty   : 1'b0;
  assign r_stall = HAS_STALL ? s_stall : 1'b0;
endmodule

// File: rtl/wbdec_resp_mux.sv
module wbdec_resp_mux #(
  parameter int N  = 4,
  parameter int DW = 32
) (
  input  logic [N-1:0]         hit,
  input  logic [N-1:0][DW-1:0] dat,
  input  logic [N-1:0]         ack,
  input  logic [N-1:0]         err,
  input  logic [N-1:0]         rty,
  input  logic [N-1:0]         stall,
  output logic [DW-1:0]        m_dat_r,
  output logic                 m_ack,
  output logic                 m_err,
  output logic                 m_rty,
  output logic                 m_stall
);
  always_comb begin
    m_dat_r = '0;
    m_ack   = 1'b0;
    m_err   = 1'b0;
    m_rty   = 1'b0;
    m_stall = 1'b0;
    for (int k = 0; k < N; k++) begin
      m_dat_r = m_dat_r | (dat[k] & {DW{hit[k]}});
      m_ack   = m_ack   | (ack[k]   & hit[k]);
      m_err   = m_err   | (err[k]   & hit[k]);
      m_rty   = m_rty   | (rty[k]   & hit[k]);
      m_stall = m_stall | (stall[k] & hit[k]);
    end
  end

  always_comb begin
    if (hit == '0) begin
      // R9
      miss_quiet_chk: assert (!m_ack && !m_err && !m_rty && !m_stall && m_dat_r == '0);
    end
  end
endmodule

// File: rtl/wb_addr_decoder.sv
module wb_addr_decoder
  import wbdec_pkg::*;
#(
  parameter int M_AW    = 20,
  parameter int M_DW    = 32,
  parameter int M_GRAN  = 16,
  parameter int S0_AW   = 7,
  parameter int S1_AW   = 6,
  parameter int S1_GRAN = 8,
  parameter int S2_AW   = 7,
  parameter int S2_DW   = 16,
  parameter int S3_AW   = 7,
  parameter int S3_DW   = 8,
  // Window bases and spans in units of M_GRAN
  parameter int S0_BASE = 32'h10000,
  parameter int S0_SPAN = 32'h100,
  parameter int S1_BASE = 32'h20000,
  parameter int S1_SPAN = 32'h80,
  parameter int S2_BASE = 32'h30000,
  parameter int S2_SPAN = 32'h100,
  parameter int S3_BASE = 32'h40000,
  parameter int S3_SPAN = 32'h100,
  localparam int M_SW   = M_DW / M_GRAN,
  localparam int S1_SW  = M_DW / S1_GRAN
) (
  input  logic              m_cyc,
  input  logic              m_stb,
  input  logic              m_we,
  input  logic [M_AW-1:0]   m_adr,
  input  logic [M_SW-1:0]   m_sel,
  input  logic [M_DW-1:0]   m_dat_w,
  input  logic              m_lock,
  input  logic [2:0]        m_cti,
  input  logic [1:0]        m_bte,
  output logic [M_DW-1:0]   m_dat_r,
  output logic              m_ack,
  output logic              m_err,
  output logic              m_rty,
  output logic              m_stall,
  output logic              s0_cyc,
  output logic              s0_stb,
  output logic              s0_we,
  output logic [S0_AW-1:0]  s0_adr,
  output logic [M_SW-1:0]   s0_sel,
  output logic [M_DW-1:0]   s0_dat_w,
  input  logic [M_DW-1:0]   s0_dat_r,
  input  logic              s0_ack,
  output logic              s1_cyc,
  output logic              s1_stb,
  output logic              s1_we,
  output logic [S1_AW-1:0]  s1_adr,
  output logic [S1_SW-1:0]  s1_sel,
  output logic [M_DW-1:0]   s1_dat_w,
  output logic              s1_lock,
  output logic [2:0]        s1_cti,
  output logic [1:0]        s1_bte,
  input  logic [M_DW-1:0]   s1_dat_r,
  input  logic              s1_ack,
  input  logic              s1_err,
  input  logic              s1_rty,
  input  logic              s1_stall,
  output logic              s2_cyc,
  output logic              s2_stb,
  output logic              s2_we,
  output logic [S2_AW-1:0]  s2_adr,
  output logic [0:0]        s2_sel,
  output logic [S2_DW-1:0]  s2_dat_w,
  input  logic [S2_DW-1:0]  s2_dat_r,
  input  logic              s2_ack,
  output logic              s3_cyc,
  output logic              s3_stb,
  output logic              s3_we,
  output logic [S3_AW-1:0]  s3_adr,
  output logic [0:0]        s3_sel,
  output logic [S3_DW-1:0]  s3_dat_w,
  input  logic [S3_DW-1:0]  s3_dat_r,
  input  logic              s3_ack
);
  // Decoder units per initiator word
  localparam int UPW = M_DW / M_GRAN;

  logic [DEC_PORTS-1:0]           hit_v;
  logic [DEC_PORTS-1:0][M_DW-1:0] r_dat;
  logic [DEC_PORTS-1:0]           r_ack, r_err, r_rty, r_stall;

  wbdec_slice #(
    .MODE(XL_DENSE), .M_AW(M_AW), .M_DW(M_DW), .M_GRAN(M_GRAN),
    .S_AW(S0_AW), .S_DW(M_DW), .S_GRAN(M_GRAN),
    .BASE_W(S0_BASE / UPW), .SPAN_W(S0_SPAN / UPW),
    .HAS_ERR(1'b0), .HAS_RTY(1'b0), .HAS_STALL(1'b0)
  ) u_slice0 (
    .m_adr(m_adr), .m_cyc(m_cyc), .m_sel(m_sel), .m_dat_w(m_dat_w),
    .hit(hit_v[0]), .s_cyc(s0_cyc), .s_adr(s0_adr), .s_sel(s0_sel),
    .s_dat_w(s0_dat_w), .s_dat_r(s0_dat_r), .s_ack(s0_ack),
    .s_err(1'b0), .s_rty(1'b0), .s_stall(1'b0),
    .r_dat(r_dat[0]), .r_ack(r_ack[0]), .r_err(r_err[0]),
    .r_rty(r_rty[0]), .r_stall(r_stall[0])
  );

  wbdec_slice #(
    .MODE(XL_DENSE), .M_AW(M_AW), .M_DW(M_DW), .M_GRAN(M_GRAN),
    .S_AW(S1_AW), .S_DW(M_DW), .S_GRAN(S1_GRAN),
    .BASE_W(S1_BASE / UPW), .SPAN_W(S1_SPAN / UPW),
    .HAS_ERR(1'b1), .HAS_RTY(1'b1), .HAS_STALL(1'b1)
  ) u_slice1 (
    .m_adr(m_adr), .m_cyc(m_cyc), .m_sel(m_sel), .m_dat_w(m_dat_w),
    .hit(hit_v[1]), .s_cyc(s1_cyc), .s_adr(s1_adr), .s_sel(s1_sel),
    .s_dat_w(s1_dat_w), .s_dat_r(s1_dat_r), .s_ack(s1_ack),
    .s_err(s1_err), .s_rty(s1_rty), .s_stall(s1_stall),
    .r_dat(r_dat[1]), .r_ack(r_ack[1]), .r_err(r_err[1]),
    .r_rty(r_rty[1]), .r_stall(r_stall[1])
  );

  wbdec_slice #(
    .MODE(XL_SPARSE), .M_AW(M_AW), .M_DW(M_DW), .M_GRAN(M_GRAN),
    .S_AW(S2_AW), .S_DW(S2_DW), .S_GRAN(S2_DW),
    .BASE_W(S2_BASE / UPW), .SPAN_W(S2_SPAN / UPW),
    .HAS_ERR(1'b0), .HAS_RTY(1'b0), .HAS_STALL(1'b0)
  ) u_slice2 (
    .m_adr(m_adr), .m_cyc(m_cyc), .m_sel(m_sel), .m_dat_w(m_dat_w),
    .hit(hit_v[2]), .s_cyc(s2_cyc), .s_adr(s2_adr), .s_sel(s2_sel),
    .s_dat_w(s2_dat_w), .s_dat_r(s2_dat_r), .s_ack(s2_ack),
    .s_err(1'b0), .s_rty(1'b0), .s_stall(1'b0),
    .r_dat(r_dat[2]), .r_ack(r_ack[2]), .r_err(r_err[2]),
    .r_rty(r_rty[2]), .r_stall(r_stall[2])
  );

  wbdec_slice #(
    .MODE(XL_SPARSE), .M_AW(M_AW), .M_DW(M_DW), .M_GRAN(M_GRAN),
    .S_AW(S3_AW), .S_DW(S3_DW), .S_GRAN(S3_DW),
    .BASE_W(S3_BASE / UPW), .SPAN_W(S3_SPAN / UPW),
    .HAS_ERR(1'b0), .HAS_RTY(1'b0), .HAS_STALL(1'b0)
  ) u_slice3 (
    .m_adr(m_adr), .m_cyc(m_cyc), .m_sel(m_sel), .m_dat_w(m_dat_w),
    .hit(hit_v[3]), .s_cyc(s3_cyc), .s_adr(s3_adr), .s_sel(s3_sel),
    .s_dat_w(s3_dat_w), .s_dat_r(s3_dat_r), .s_ack(s3_ack),
    .s_err(1'b0), .s_rty(1'b0), .s_stall(1'b0),
    .r_dat(r_dat[3]), .r_ack(r_ack[3]), .r_err(r_err[3]),
    .r_rty(r_rty[3]), .r_stall(r_stall[3])
  );

  wbdec_resp_mux #(
    .N (DEC_PORTS),
    .DW(M_DW)
  ) u_resp (
    .hit    (hit_v),
    .dat    (r_dat),
    .ack    (r_ack),
    .err    (r_err),
    .rty    (r_rty),
    .stall  (r_stall),
    .m_dat_r(m_dat_r),
    .m_ack  (m_ack),
    .m_err  (m_err),
    .m_rty  (m_rty),
    .m_stall(m_stall)
  );

  // Request qualifiers fan out to every subordinate; only cyc is gated
  assign s0_stb  = m_stb;
  assign s1_stb  = m_stb;
  assign s2_stb  = m_stb;
  assign s3_stb  = m_stb;
  assign s0_we   = m_we;
  assign s1_we   = m_we;
  assign s2_we   = m_we;
  assign s3_we   = m_we;
  assign s1_lock = m_lock;
  assign s1_cti  = m_cti;
  assign s1_bte  = m_bte;

  always_comb begin
    // R1
    cyc_onehot_chk: assert ($onehot0({s3_cyc, s2_cyc, s1_cyc, s0_cyc}));
    if (s1_cyc) begin
      // R3
      s1_resp_chk: assert (m_stall == s1_stall && m_err == s1_err && m_dat_r == s1_dat_r);
    end
    if (s0_cyc || s2_cyc || s3_cyc) begin
      // R5
      no_opt_resp_chk: assert (!m_err && !m_rty && !m_stall);
    end
  end
endmodule

// File: tb/wb_addr_decoder_bench.sv
module wb_addr_decoder_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic        m_cyc, m_stb, m_we, m_lock;
  logic [19:0] m_adr;
  logic [1:0]  m_sel, m_bte;
  logic [31:0] m_dat_w, m_dat_r;
  logic [2:0]  m_cti;
  logic        m_ack, m_err, m_rty, m_stall;
  logic        s0_cyc, s0_stb, s0_we, s0_ack;
  logic [6:0]  s0_adr;
  logic [1:0]  s0_sel;
  logic [31:0] s0_dat_w, s0_dat_r;
  logic        s1_cyc, s1_stb, s1_we, s1_lock, s1_ack, s1_err, s1_rty, s1_stall;
  logic [5:0]  s1_adr;
  logic [3:0]  s1_sel;
  logic [31:0] s1_dat_w, s1_dat_r;
  logic [2:0]  s1_cti;
  logic [1:0]  s1_bte;
  logic        s2_cyc, s2_stb, s2_we, s2_ack;
  logic [6:0]  s2_adr;
  logic [0:0]  s2_sel;
  logic [15:0] s2_dat_w, s2_dat_r;
  logic        s3_cyc, s3_stb, s3_we, s3_ack;
  logic [6:0]  s3_adr;
  logic [0:0]  s3_sel;
  logic [7:0]  s3_dat_w, s3_dat_r;

  logic [3:0] ack_en;
  logic       f_err, f_rty, f_stall;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  wb_addr_decoder u_wb_addr_decoder (.*);

  // Loopback subordinates: each selected lane returns address + lane index
  always_comb begin
    s0_dat_r = '0;
    for (int i = 0; i < 2; i++)
      if (s0_sel[i]) s0_dat_r[16*i +: 16] = 16'(s0_adr) + 16'(i);
    s1_dat_r = '0;
    for (int i = 0; i < 4; i++)
      if (s1_sel[i]) s1_dat_r[8*i +: 8] = 8'(s1_adr) + 8'(i);
    s2_dat_r = s2_sel[0] ? 16'(s2_adr) : 16'h0;
    s3_dat_r = s3_sel[0] ? 8'(s3_adr)  : 8'h0;
  end
  assign s0_ack   = s0_stb & ack_en[0];
  assign s1_ack   = s1_stb & ack_en[1];
  assign s2_ack   = s2_stb & ack_en[2];
  assign s3_ack   = s3_stb & ack_en[3];
  assign s1_err   = f_err;
  assign s1_rty   = f_rty;
  assign s1_stall = f_stall;

  function automatic logic [19:0] base_w(int k);
    case (k)
      0:       return 20'h08000;
      1:       return 20'h10000;
      2:       return 20'h18000;
      default: return 20'h20000;
    endcase
  endfunction

  // Expected read data from the requirements (R6, R7)
  function automatic logic [31:0] exp_dat(int k, int off, logic [1:0] sel);
    logic [31:0] r = '0;
    case (k)
      0: for (int i = 0; i < 2; i++) if (sel[i]) r[16*i +: 16] = 16'(off + i);
      1: for (int i = 0; i < 4; i++) if (sel[i/2]) r[8*i +: 8] = 8'(off + i);
      2: if (sel[0]) r[15:0] = 16'(off);
      default: if (sel[0]) r[7:0] = 8'(off);
    endcase
    return r;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(logic cyc, logic [19:0] adr, logic [1:0] sel);
    @(negedge clk);
    m_cyc = cyc;
    m_adr = adr;
    m_sel = sel;
    #5;
  endtask

  function automatic logic [3:0] cyc_vec();
    return {s3_cyc, s2_cyc, s1_cyc, s0_cyc};
  endfunction

  task automatic t_idle();
    drive(1'b0, 20'h00000, 2'b00);
    chk("R1", "idle cyc", 32'(cyc_vec()), 32'h0);
    chk("R9", "idle ack", 32'(m_ack), 32'h0);
    chk("R9", "idle dat_r", m_dat_r, 32'h0);
  endtask

  task automatic t_gating();
    for (int k = 0; k < 4; k++) begin
      drive(1'b1, base_w(k) + 20'd5, 2'b11);
      chk("R1", "cyc only on owner", 32'(cyc_vec()), 32'(4'b0001 << k));
      drive(1'b0, base_w(k) + 20'd5, 2'b11);
      chk("R1", "cyc low without m_cyc", 32'(cyc_vec()), 32'h0);
    end
  endtask

  task automatic t_broadcast();
    @(negedge clk);
    m_stb = 1'b1; m_we = 1'b1; m_dat_w = 32'h1234_5678;
    drive(1'b1, base_w(0) + 20'd3, 2'b10);
    chk("R2", "s1_stb unselected", 32'(s1_stb), 32'h1);
    chk("R2", "s3_we unselected", 32'(s3_we), 32'h1);
    chk("R2", "s1_dat_w unselected", s1_dat_w, 32'h1234_5678);
    chk("R2", "s1_sel unselected", 32'(s1_sel), 32'hC);
    chk("R7", "s2_dat_w low lane", 32'(s2_dat_w), 32'h5678);
    chk("R7", "s3_dat_w low lane", 32'(s3_dat_w), 32'h78);
    chk("R7", "s2_sel follows sel0", 32'(s2_sel), 32'h0);
    chk("R6", "s0_sel equals m_sel", 32'(s0_sel), 32'h2);
    @(negedge clk);
    m_we = 1'b0;
  endtask

  task automatic t_resp();
    @(negedge clk);
    ack_en = 4'b1111; f_err = 1'b1; f_rty = 1'b1; f_stall = 1'b1;
    drive(1'b1, base_w(1) + 20'd2, 2'b11);
    chk("R3", "ack from s1", 32'(m_ack), 32'h1);
    chk("R3", "err from s1", 32'(m_err), 32'h1);
    chk("R3", "rty from s1", 32'(m_rty), 32'h1);
    chk("R3", "stall from s1", 32'(m_stall), 32'h1);
    for (int k = 0; k < 4; k++) begin
      if (k == 1) continue;
      drive(1'b1, base_w(k) + 20'd2, 2'b11);
      chk("R5", "err zero for plain sub", 32'(m_err), 32'h0);
      chk("R5", "rty zero for plain sub", 32'(m_rty), 32'h0);
      chk("R5", "stall zero for plain sub", 32'(m_stall), 32'h0);
    end
    @(negedge clk);
    ack_en = 4'b1110;
    drive(1'b1, base_w(0) + 20'd2, 2'b11);
    chk("R3", "other subs' ack ignored", 32'(m_ack), 32'h0);
    @(negedge clk);
    ack_en = 4'b0001;
    drive(1'b1, base_w(0) + 20'd2, 2'b11);
    chk("R3", "ack from s0", 32'(m_ack), 32'h1);
    @(negedge clk);
    f_err = 1'b0; f_rty = 1'b0; f_stall = 1'b0;
  endtask

  task automatic t_fwd();
    @(negedge clk);
    m_lock = 1'b1; m_cti = 3'b010; m_bte = 2'b01;
    #5;
    chk("R4", "lock", 32'(s1_lock), 32'h1);
    chk("R4", "cti", 32'(s1_cti), 32'h2);
    chk("R4", "bte", 32'(s1_bte), 32'h1);
    @(negedge clk);
    m_lock = 1'b0; m_cti = 3'b111; m_bte = 2'b11;
    #5;
    chk("R4", "lock low", 32'(s1_lock), 32'h0);
    chk("R4", "cti 7", 32'(s1_cti), 32'h7);
    chk("R4", "bte 3", 32'(s1_bte), 32'h3);
  endtask

  task automatic t_readback();
    int offs[3] = '{8, 9, 33};
    for (int k = 0; k < 4; k++) begin
      for (int o = 0; o < 3; o++) begin
        for (int s = 0; s < 4; s++) begin
          drive(1'b1, base_w(k) + 20'(offs[o]), 2'(s));
          chk(k < 2 ? "R6" : "R7", $sformatf("read sub%0d off%0d sel%0d", k, offs[o], s),
              m_dat_r, exp_dat(k, offs[o], 2'(s)));
        end
      end
    end
    drive(1'b1, base_w(1) + 20'd8, 2'b01);
    chk("R6", "s1_sel expand 01", 32'(s1_sel), 32'h3);
  endtask

  task automatic t_addr();
    drive(1'b1, base_w(0) + 20'h45, 2'b11);
    chk("R8", "s0_adr", 32'(s0_adr), 32'h45);
    drive(1'b1, base_w(1) + 20'h2A, 2'b11);
    chk("R8", "s1_adr", 32'(s1_adr), 32'h2A);
    drive(1'b1, base_w(2) + 20'h7E, 2'b11);
    chk("R8", "s2_adr", 32'(s2_adr), 32'h7E);
    drive(1'b1, base_w(3) + 20'h11, 2'b11);
    chk("R8", "s3_adr", 32'(s3_adr), 32'h11);
  endtask

  task automatic t_miss();
    logic [19:0] holes[4] = '{20'h00000, 20'h07FFF, 20'h10040, 20'hFFFFF};
    @(negedge clk);
    ack_en = 4'b1111; f_err = 1'b1; f_rty = 1'b1; f_stall = 1'b1;
    foreach (holes[h]) begin
      drive(1'b1, holes[h], 2'b11);
      chk("R9", $sformatf("miss cyc at %h", holes[h]), 32'(cyc_vec()), 32'h0);
      chk("R9", "miss flags", 32'({m_ack, m_err, m_rty, m_stall}), 32'h0);
      chk("R9", "miss dat_r", m_dat_r, 32'h0);
    end
    @(negedge clk);
    f_err = 1'b0; f_rty = 1'b0; f_stall = 1'b0;
  endtask

  task automatic t_bounds();
    int last[4] = '{'h7F, 'h3F, 'h7F, 'h7F};
    for (int k = 0; k < 4; k++) begin
      drive(1'b1, base_w(k), 2'b11);
      chk("R10", $sformatf("first word sub%0d", k), 32'(cyc_vec()), 32'(4'b0001 << k));
      drive(1'b1, base_w(k) + 20'(last[k]), 2'b11);
      chk("R10", $sformatf("last word sub%0d", k), 32'(cyc_vec()), 32'(4'b0001 << k));
      chk("R10", $sformatf("last word data sub%0d", k), m_dat_r, exp_dat(k, last[k], 2'b11));
      drive(1'b1, base_w(k) + 20'(last[k]) + 20'd1, 2'b11);
      chk("R10", $sformatf("past end sub%0d", k), 32'(cyc_vec()), 32'h0);
      drive(1'b1, base_w(k) - 20'd1, 2'b11);
      chk("R10", $sformatf("below base sub%0d", k), 32'(cyc_vec()), 32'h0);
    end
  endtask

  initial begin
    m_cyc = 1'b0; m_stb = 1'b0; m_we = 1'b0; m_adr = '0; m_sel = '0;
    m_dat_w = '0; m_lock = 1'b0; m_cti = '0; m_bte = '0;
    ack_en = '0; f_err = 1'b0; f_rty = 1'b0; f_stall = 1'b0;
    repeat (2) @(negedge clk);
    t_idle();
    t_gating();
    t_broadcast();
    t_resp();
    t_fwd();
    t_readback();
    t_addr();
    t_miss();
    t_bounds();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule